// File: doc/BRIEF.md
# Paired-Write Configuration Port

This block is the configuration front end of a legacy I/O controller. Software selects a register through an index port, then changes that register through a data port. A data write only takes effect when it comes directly after an earlier data write. The first write of a pair is therefore discarded, which guards the configuration against a single stray store. Any read, or any new index write, breaks a pair that has been started.

The block holds a file of 29 configuration bytes. From these bytes it continuously decodes the resources for its peripherals:

- the enable and I/O base of a parallel port;
- the enable, base address and interrupt line of two serial ports;
- the enable and base of a floppy controller.

Several registers follow special write rules. One register is a fixed identification value. One is a parallel base that stays locked until a control bit opens it. The main enable register has a mask and a substitution value.

The bus is a single-cycle strobe interface. With `req` high for one clock, `wr` selects write (1) or read (0), and `addr` selects the index port (0) or the data port (1). Read data is combinational while `req` is high.

Top module: `dblwr_cfg_port`

## Requirements
- R1: An index write (wr=1, addr=0) stores wdata[4:0] as the current index. A read of the index port returns that index, with bits 7:5 zero.
- R2: On a data write (wr=1, addr=1) when no pair is open, the write is discarded and a pair is opened. The next data write commits its own value to the indexed register and closes the pair, so a third consecutive write opens a new pair.
- R3: Any read, of either port, closes an open pair. An index write also closes it. A data write after either event only opens a new pair.
- R4: A committed write of 0x08 to register 0 stores 0x4B. Any other value written to register 0 is stored ANDed with 0x5F, so bits 7 and 5 of register 0 are always zero.
- R5: Register 8 always reads 0x70 and ignores writes. Indices 28 to 31 always read 0xFF. Writes to indices 29 to 31 are discarded. A write to index 28 is stored.
- R6: Register 0x19 accepts writes only while bit 6 of register 0x1B is 1. A committed write to 0x1B with bit 6 equal to 0 reloads register 0x19 with 0xEF.
- R7: The parallel port is enabled by register 0 bit 0, and its base is chosen by register 1 bits 1:0:
  - 0 gives 0x378;
  - 1 gives 0x3BC, or register 0x19 shifted left by 2 when register 0x1B bit 6 is 1;
  - 2 gives 0x278;
  - 3 disables the port.
- R8: Serial port 1 takes its select from register 1 bits 3:2, and serial port 2 from bits 5:4. Select 0 gives 0x3F8 and select 1 gives 0x2F8. For select 2, register 1 bits 7:6 (values 0 to 3) pick 0x3E8, 0x338, 0x2E8 or 0x220. For select 3 they pick 0x2E8, 0x238, 0x2E0 or 0x228. Register 0 bit 1 enables port 1, and bit 2 enables port 2.
- R9: When register 0x1C bit 0 is 1, the serial IRQ is 4 if register 0x1C bit 2 (port 1) or bit 6 (port 2) is 1, and 3 if that bit is 0. Otherwise the IRQ is 4 for even selects and 3 for odd selects.
- R10: Register 0 bit 3 enables the floppy controller. Its base is 0x370 when register 0 bit 5 is 1 and 0x3F0 when it is 0. While register 2 bit 0 is 1, the parallel port, both serial ports and the floppy controller are all disabled.
- R11: Reset closes any open pair and sets the index to 0. It loads these register values, and every other register reads 0:

  | Register | Reset value |
  |---|---|
  | 0 | 0x0B |
  | 1 | 0x01 |
  | 3 | 0x01 |
  | 5 | 0x0D |
  | 9 | 0xC0 |
  | 0x0B | 0x80 |
  | 0x0F | 0x1E |
  | 0x12 | 0x30 |
  | 0x19 | 0xEF |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Single-cycle access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while req is high |
| par_en | output | 1 | Parallel port enable |
| par_base | output | 10 | Parallel port I/O base |
| ser1_en | output | 1 | Serial port 1 enable |
| ser1_base | output | 10 | Serial port 1 I/O base |
| ser1_irq | output | 4 | Serial port 1 interrupt line |
| ser2_en | output | 1 | Serial port 2 enable |
| ser2_base | output | 10 | Serial port 2 I/O base |
| ser2_irq | output | 4 | Serial port 2 interrupt line |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_base | output | 10 | Floppy controller I/O base |

## Verification
The assertions assume that `req`, `wr` and `addr` are driven to known values in every cycle after reset. They also assume that a read's `rdata` is looked at only while its strobe is high. The stimulus meets these assumptions: it changes every bus input half a cycle away from the sampling edge, and it holds `req` for exactly one clock per access. Between accesses it leaves idle cycles, which do not alter the open-pair state, so each sequence of writes and reads is seen exactly as the requirements describe.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;

    localparam int DW      = 8;
    localparam int IDX_W   = 5;
    localparam int NREG    = 29;
    localparam int IO_W    = 10;
    localparam int IRQ_W   = 4;
    localparam int RD_TOP  = 28;

    localparam logic [IDX_W-1:0] R_ENA   = 5'h00;
    localparam logic [IDX_W-1:0] R_ADDR  = 5'h01;
    localparam logic [IDX_W-1:0] R_PWR   = 5'h02;
    localparam logic [IDX_W-1:0] R_ID    = 5'h08;
    localparam logic [IDX_W-1:0] R_PBASE = 5'h19;
    localparam logic [IDX_W-1:0] R_PCTL  = 5'h1B;
    localparam logic [IDX_W-1:0] R_IRQ   = 5'h1C;

    localparam logic [DW-1:0] ENA_MASK    = 8'h5F;
    localparam logic [DW-1:0] ENA_MAGIC   = 8'h08;
    localparam logic [DW-1:0] ENA_SUBST   = 8'h4B;
    localparam logic [DW-1:0] ID_VALUE    = 8'h70;
    localparam logic [DW-1:0] PBASE_INIT  = 8'hEF;
    localparam logic [DW-1:0] VOID_VALUE  = 8'hFF;

    typedef struct packed {
        logic [3:0]      ena;
        logic            fdc_alt;
        logic            all_off;
        logic [1:0]      par_sel;
        logic [1:0][1:0] ser_sel;
        logic [1:0]      uart_ext;
        logic            pbase_ovr;
        logic [DW-1:0]   pbase;
        logic            irq_ovr;
        logic [1:0]      irq_hi;
    } cfg_ctl_t;

    typedef struct packed {
        logic            en;
        logic [IO_W-1:0] base;
    } io_res_t;

    typedef struct packed {
        logic             en;
        logic [IO_W-1:0]  base;
        logic [IRQ_W-1:0] irq;
    } ser_res_t;

    function automatic logic [DW-1:0] reset_value(input int idx);
        case (idx)
            0:       return 8'h0B;
            1:       return 8'h01;
            3:       return 8'h01;
            5:       return 8'h0D;
            8:       return ID_VALUE;
            9:       return 8'hC0;
            11:      return 8'h80;
            15:      return 8'h1E;
            18:      return 8'h30;
            25:      return PBASE_INIT;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [IO_W-1:0] uart_base(input logic [1:0] sel,
                                                   input logic [1:0] ext);
        logic [IO_W-1:0] b;
        case (sel)
            2'd0: b = 10'h3F8;
            2'd1: b = 10'h2F8;
            2'd2: case (ext)
                      2'd0: b = 10'h3E8;
                      2'd1: b = 10'h338;
                      2'd2: b = 10'h2E8;
                      default: b = 10'h220;
                  endcase
            default: case (ext)
                      2'd0: b = 10'h2E8;
                      2'd1: b = 10'h238;
                      2'd2: b = 10'h2E0;
                      default: b = 10'h228;
                  endcase
        endcase
        return b;
    endfunction

    function automatic logic [IRQ_W-1:0] uart_irq(input logic sel_odd,
                                                  input logic ovr,
                                                  input logic hi);
        if (ovr)
            return hi ? 4'd4 : 4'd3;
        return sel_odd ? 4'd3 : 4'd4;
    endfunction

endpackage

// File: rtl/cfgp_seq.sv
`timescale 1ns/1ps
module cfgp_seq
    import cfgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             wr,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    output logic [IDX_W-1:0] idx,
    output logic             commit
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            armed <= 1'b0;
        end else if (req) begin
            if (!wr) begin
                armed <= 1'b0;
            end else if (!addr) begin
                idx   <= wdata[IDX_W-1:0];
                armed <= 1'b0;
            end else begin
                armed <= !armed;
            end
        end
    end

    assign commit = req && wr && addr && armed;

    // R2: a lone data write opens the pair
    a_r2_open_pair: assert property (@(posedge clk) disable iff (rst)
        (req && wr && addr && !armed) |=> armed);

    // R2: a committing write closes the pair
    a_r2_commit_closes: assert property (@(posedge clk) disable iff (rst)
        commit |=> !armed);

    // R3: reads and index writes break a pair
    a_r3_break_pair: assert property (@(posedge clk) disable iff (rst)
        (req && (!wr || !addr)) |=> !armed);

endmodule

// File: rtl/cfgp_regfile.sv
`timescale 1ns/1ps
module cfgp_regfile
    import cfgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    input  logic             rd_data_port,
    output logic [DW-1:0]    rdata,
    output cfg_ctl_t         ctl
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);
    localparam logic [IDX_W-1:0] VOID_IDX = IDX_W'(RD_TOP);

    logic [DW-1:0] rf_q [NREG];
    logic [DW-1:0] rf_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++)
            rf_d[i] = rf_q[i];
        if (commit && idx <= LAST_IDX && idx != R_ID) begin
            unique case (idx)
                R_ENA:
                    rf_d[R_ENA] = (wdata == ENA_MAGIC) ? ENA_SUBST
                                                       : (wdata & ENA_MASK);
                R_PBASE:
                    if (rf_q[R_PCTL][6])
                        rf_d[R_PBASE] = wdata;
                R_PCTL: begin
                    rf_d[R_PCTL] = wdata;
                    if (!wdata[6])
                        rf_d[R_PBASE] = PBASE_INIT;
                end
                default:
                    rf_d[idx] = wdata;
            endcase
        end
        rf_d[R_ID] = ID_VALUE;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst)
                rf_q[i] <= reset_value(i);
            else
                rf_q[i] <= rf_d[i];
        end
    end

    always_comb begin
        if (!rd_data_port)
            rdata = {{(DW-IDX_W){1'b0}}, idx};
        else if (idx >= VOID_IDX)
            rdata = VOID_VALUE;
        else
            rdata = rf_q[idx];
    end

    assign ctl.ena       = rf_q[R_ENA][3:0];
    assign ctl.fdc_alt   = rf_q[R_ENA][5];
    assign ctl.all_off   = rf_q[R_PWR][0];
    assign ctl.par_sel   = rf_q[R_ADDR][1:0];
    assign ctl.ser_sel   = {rf_q[R_ADDR][5:4], rf_q[R_ADDR][3:2]};
    assign ctl.uart_ext  = rf_q[R_ADDR][7:6];
    assign ctl.pbase_ovr = rf_q[R_PCTL][6];
    assign ctl.pbase     = rf_q[R_PBASE];
    assign ctl.irq_ovr   = rf_q[R_IRQ][0];
    assign ctl.irq_hi    = {rf_q[R_IRQ][6], rf_q[R_IRQ][2]};

    // R6: while the parallel base is locked it holds its reload value
    a_r6_pbase_locked: assert property (@(posedge clk) disable iff (rst)
        !rf_q[R_PCTL][6] |-> (rf_q[R_PBASE] == PBASE_INIT));

    // R4: masked bits of the enable register never become set
    a_r4_ena_masked: assert property (@(posedge clk) disable iff (rst)
        (rf_q[R_ENA] & ~ENA_MASK) == '0);

    // R5: the identification register reads its fixed value
    a_r5_id_fixed: assert property (@(posedge clk) disable iff (rst)
        (rd_data_port && idx == R_ID) |-> (rdata == ID_VALUE));

endmodule

// File: rtl/cfgp_decode.sv
`timescale 1ns/1ps
module cfgp_decode
    import cfgp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cfg_ctl_t           ctl,
    output io_res_t            par,
    output ser_res_t [1:0]     ser,
    output io_res_t            fdc
);

    logic live;
    assign live = !ctl.all_off;

    always_comb begin
        par.en = live && ctl.ena[0] && (ctl.par_sel != 2'd3);
        case (ctl.par_sel)
            2'd0:    par.base = 10'h378;
            2'd1:    par.base = ctl.pbase_ovr ? {ctl.pbase, 2'b00} : 10'h3BC;
            2'd2:    par.base = 10'h278;
            default: par.base = '0;
        endcase
    end

    for (genvar p = 0; p < 2; p++) begin : g_uart
        always_comb begin
            ser[p].en   = live && ctl.ena[1 + p];
            ser[p].base = uart_base(ctl.ser_sel[p], ctl.uart_ext);
            ser[p].irq  = uart_irq(ctl.ser_sel[p][0], ctl.irq_ovr, ctl.irq_hi[p]);
        end

        // R9: only lines 3 and 4 are ever produced
        a_r9_irq_line: assert property (@(posedge clk) disable iff (rst)
            (ser[p].irq == 4'd3) || (ser[p].irq == 4'd4));
    end

    always_comb begin
        fdc.en   = live && ctl.ena[3];
        fdc.base = ctl.fdc_alt ? 10'h370 : 10'h3F0;
    end

    // R10: power-down leaves every resource disabled
    a_r10_all_off: assert property (@(posedge clk) disable iff (rst)
        ctl.all_off |-> !(par.en || ser[0].en || ser[1].en || fdc.en));

endmodule

// File: rtl/dblwr_cfg_port.sv
`timescale 1ns/1ps
module dblwr_cfg_port
    import cfgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             wr,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             par_en,
    output logic [IO_W-1:0]  par_base,
    output logic             ser1_en,
    output logic [IO_W-1:0]  ser1_base,
    output logic [IRQ_W-1:0] ser1_irq,
    output logic             ser2_en,
    output logic [IO_W-1:0]  ser2_base,
    output logic [IRQ_W-1:0] ser2_irq,
    output logic             fdc_en,
    output logic [IO_W-1:0]  fdc_base
);

    logic [IDX_W-1:0] idx;
    logic             commit;
    cfg_ctl_t         ctl;
    io_res_t          par;
    ser_res_t [1:0]   ser;
    io_res_t          fdc;

    cfgp_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .wr     (wr),
        .addr   (addr),
        .wdata  (wdata),
        .idx    (idx),
        .commit (commit)
    );

    cfgp_regfile u_rf (
        .clk          (clk),
        .rst          (rst),
        .commit       (commit),
        .idx          (idx),
        .wdata        (wdata),
        .rd_data_port (addr),
        .rdata        (rdata),
        .ctl          (ctl)
    );

    cfgp_decode u_dec (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .par (par),
        .ser (ser),
        .fdc (fdc)
    );

    assign par_en    = par.en;
    assign par_base  = par.base;
    assign ser1_en   = ser[0].en;
    assign ser1_base = ser[0].base;
    assign ser1_irq  = ser[0].irq;
    assign ser2_en   = ser[1].en;
    assign ser2_base = ser[1].base;
    assign ser2_irq  = ser[1].irq;
    assign fdc_en    = fdc.en;
    assign fdc_base  = fdc.base;

    // R1: the index port reads back the low bits of the last index write
    a_r1_index_echo: assert property (@(posedge clk) disable iff (rst)
        (req && wr && !addr) |=> (addr || (rdata == {3'b000, $past(wdata[IDX_W-1:0])})));

endmodule

// File: tb/dblwr_cfg_port_test.sv
`timescale 1ns/1ps
module dblwr_cfg_port_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       wr = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       par_en, ser1_en, ser2_en, fdc_en;
    logic [9:0] par_base, ser1_base, ser2_base, fdc_base;
    logic [3:0] ser1_irq, ser2_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dblwr_cfg_port uut (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .par_en(par_en), .par_base(par_base),
        .ser1_en(ser1_en), .ser1_base(ser1_base), .ser1_irq(ser1_irq),
        .ser2_en(ser2_en), .ser2_base(ser2_base), .ser2_irq(ser2_irq),
        .fdc_en(fdc_en), .fdc_base(fdc_base)
    );

    // {is_write, index, value, expected readback}
    localparam int NV = 12;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'h00, 8'h08, 8'h4B},   // R4 substitution
        {1'b1, 8'h00, 8'hFF, 8'h5F},   // R4 mask
        {1'b1, 8'h08, 8'h12, 8'h70},   // R5 fixed id
        {1'b1, 8'h1D, 8'h33, 8'hFF},   // R5 void index
        {1'b1, 8'h1C, 8'h00, 8'hFF},   // R5 index 28 reads FF
        {1'b1, 8'h19, 8'h20, 8'hEF},   // R6 locked
        {1'b1, 8'h1B, 8'h40, 8'h40},   // R6 unlock
        {1'b1, 8'h19, 8'h20, 8'h20},   // R6 open write
        {1'b1, 8'h1B, 8'h00, 8'h00},   // R6 relock
        {1'b0, 8'h19, 8'h00, 8'hEF},   // R6 reload
        {1'b1, 8'h25, 8'h77, 8'h77},   // R1 index masked to 5
        {1'b1, 8'h00, 8'h0B, 8'h0B}    // R4 restore
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] v);
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = a;
        #1 v = rdata;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] i, input logic [7:0] v);
        bus_wr(1'b0, i);
        bus_wr(1'b1, v);
        bus_wr(1'b1, v);
    endtask

    task automatic get_reg(input logic [7:0] i, output logic [7:0] v);
        bus_wr(1'b0, i);
        bus_rd(1'b1, v);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        do_reset();

        // R11 reset values and resulting decode
        get_reg(8'h00, v); chk(v, 8'h0B, "R11 reg0");
        get_reg(8'h01, v); chk(v, 8'h01, "R11 reg1");
        get_reg(8'h05, v); chk(v, 8'h0D, "R11 reg5");
        get_reg(8'h0F, v); chk(v, 8'h1E, "R11 regF");
        get_reg(8'h12, v); chk(v, 8'h30, "R11 reg12");
        get_reg(8'h19, v); chk(v, 8'hEF, "R11 reg19");
        get_reg(8'h04, v); chk(v, 8'h00, "R11 reg4");
        chk(par_en, 1, "R11 par_en");      chk(par_base, 10'h3BC, "R7 par_base reset");
        chk(ser1_en, 1, "R11 ser1_en");    chk(ser1_base, 10'h3F8, "R8 ser1_base reset");
        chk(ser1_irq, 4, "R9 ser1_irq reset");
        chk(ser2_en, 0, "R11 ser2_en");
        chk(fdc_en, 1, "R10 fdc_en reset"); chk(fdc_base, 10'h3F0, "R10 fdc_base reset");

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic        is_w;
            logic [7:0]  ix, val, exp;
            {is_w, ix, val, exp} = VEC[i];
            if (is_w) set_reg(ix, val);
            else bus_wr(1'b0, ix);
            bus_rd(1'b1, v);
            chk(v, exp, $sformatf("vector %0d idx 0x%0h (R4/R5/R6)", i, ix));
        end

        // R1 index readback
        bus_wr(1'b0, 8'h25);
        bus_rd(1'b0, v); chk(v, 8'h05, "R1 index read");

        // R2 single write discarded, pair commits second value
        bus_wr(1'b0, 8'h03);
        bus_wr(1'b1, 8'h55);
        bus_rd(1'b1, v); chk(v, 8'h01, "R2 single write discarded");
        // R3 read breaks pair
        bus_wr(1'b1, 8'hAA);
        bus_rd(1'b1, v);
        bus_wr(1'b1, 8'hBB);
        bus_rd(1'b1, v); chk(v, 8'h01, "R3 read breaks pair");
        // R3 index write breaks pair
        bus_wr(1'b1, 8'h11);
        bus_wr(1'b0, 8'h03);
        bus_wr(1'b1, 8'h22);
        bus_rd(1'b1, v); chk(v, 8'h01, "R3 index write breaks pair");
        // R2 three writes: second commits, third only opens
        bus_wr(1'b1, 8'h01);
        bus_wr(1'b1, 8'h02);
        bus_wr(1'b1, 8'h03);
        bus_rd(1'b1, v); chk(v, 8'h02, "R2 three writes");
        bus_wr(1'b1, 8'hCC);
        bus_wr(1'b1, 8'hDD);
        bus_rd(1'b1, v); chk(v, 8'hDD, "R2 pair commits second");

        // R7 parallel base override and selects
        set_reg(8'h1B, 8'h40);
        set_reg(8'h19, 8'hAA);
        chk(par_base, 10'h2A8, "R7 override base"); chk(par_en, 1, "R7 par_en");
        set_reg(8'h1B, 8'h00);
        chk(par_base, 10'h3BC, "R7 override cleared");
        get_reg(8'h19, v); chk(v, 8'hEF, "R6 reload on clear");
        set_reg(8'h01, 8'h02); chk(par_base, 10'h278, "R7 select 2");
        set_reg(8'h01, 8'h03); chk(par_en, 0, "R7 select 3 disables");

        // R8 / R9 serial decode
        set_reg(8'h01, 8'hB9);
        chk(ser1_base, 10'h2E8, "R8 ser1 sel2 ext2"); chk(ser1_irq, 4, "R9 ser1 even");
        chk(ser2_base, 10'h2E0, "R8 ser2 sel3 ext2"); chk(ser2_irq, 3, "R9 ser2 odd");
        chk(par_base, 10'h3BC, "R7 select 1");
        set_reg(8'h01, 8'h64);
        chk(par_base, 10'h378, "R7 select 0");
        chk(ser1_base, 10'h2F8, "R8 ser1 sel1"); chk(ser1_irq, 3, "R9 ser1 odd");
        chk(ser2_base, 10'h338, "R8 ser2 sel2 ext1"); chk(ser2_irq, 4, "R9 ser2 even");
        set_reg(8'h1C, 8'h05);
        chk(ser1_irq, 4, "R9 override port1 hi"); chk(ser2_irq, 3, "R9 override port2 lo");
        set_reg(8'h1C, 8'h41);
        chk(ser1_irq, 3, "R9 override port1 lo"); chk(ser2_irq, 4, "R9 override port2 hi");
        set_reg(8'h1C, 8'h00);

        // R10 enables and global off
        set_reg(8'h00, 8'h07);
        chk(fdc_en, 0, "R10 fdc disabled"); chk(ser2_en, 1, "R8 ser2 enabled");
        chk(par_en, 1, "R7 par enabled");
        set_reg(8'h02, 8'h01);
        chk({par_en, ser1_en, ser2_en, fdc_en}, 4'b0000, "R10 global off");
        set_reg(8'h02, 8'h00);
        chk({par_en, ser1_en, ser2_en}, 3'b111, "R10 global on");
        set_reg(8'h00, 8'h2B);
        get_reg(8'h00, v); chk(v, 8'h0B, "R4 bit5 masked");
        chk(fdc_base, 10'h3F0, "R10 fdc base");

        // R11 reset closes an open pair
        bus_wr(1'b1, 8'h07);
        do_reset();
        bus_wr(1'b1, 8'h07);
        bus_rd(1'b1, v); chk(v, 8'h0B, "R11 reset closes pair");
        get_reg(8'h1C, v); chk(v, 8'hFF, "R5 index 28");

        finish_run();
    end

endmodule